// File: doc/BRIEF.md
# Symbol-to-Slot Lookup Table with Oldest-Entry Replacement

This block keeps a small associative table that turns a symbol identifier into the index of a queue slot. Each lookup request carries one symbol, and all resident entries are compared against it at once. If the symbol is resident, the block returns the slot that holds it. If it is not, the block claims a slot for it. It takes the lowest unused slot when one exists. When every slot is occupied, it takes the slot of the symbol that was installed earliest.

When a resident symbol is displaced, the response carries a replacement flag and the displaced symbol. Logic downstream can then empty the queue tied to that slot before it is reused. One request can be accepted on every clock cycle. A request sees the table as updated by the request before it, so repeated or interleaved symbols resolve correctly with no stalls. A synchronous clear empties the table.

Top module: `sym_slot_mapper`

## Requirements
- R1: After reset, rsp_valid_o is 0 and the table holds no symbols, so the first lookup is a miss that is placed in slot 0.
- R2: A lookup of a resident symbol gives, on the cycle after the request, rsp_valid_o=1, rsp_hit_o=1, rsp_new_o=0, rsp_evict_o=0, and rsp_slot_o equal to the slot that holds the symbol.
- R3: A lookup of an absent symbol while a slot is unused places the symbol in the lowest-numbered unused slot. The response is rsp_hit_o=0, rsp_new_o=1, rsp_evict_o=0, with that slot on rsp_slot_o.
- R4: A lookup of an absent symbol while the table is full overwrites the slot chosen by the replacement pointer. The response is rsp_hit_o=0, rsp_new_o=0, rsp_evict_o=1, with that slot on rsp_slot_o and the displaced symbol on rsp_evict_sym_o.
- R5: The replacement pointer starts at slot 0, moves forward by one on each replacement, and wraps from slot DEPTH-1 to slot 0. Replacements therefore follow installation order.
- R6: A hit does not change the replacement order. A symbol that was looked up again is still displaced first if it was installed first.
- R7: A request can be issued on every cycle. A request sees any entry installed by the request one cycle earlier, so a symbol requested twice in a row misses once and then hits.
- R8: A cycle with clr_i=1 empties the table and returns the replacement pointer to slot 0. A request in that same cycle is dropped, and rsp_valid_o is 0 on the next cycle.
- R9: rsp_valid_o is 1 only on the cycle after an accepted request. When it is 0, rsp_hit_o, rsp_new_o and rsp_evict_o are all 0.
- R10: Once a symbol has been displaced, a later lookup of it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all entries and of the replacement pointer |
| req_valid_i | input | 1 | Lookup request strobe |
| req_sym_i | input | SYM_W | Symbol to look up |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Symbol was already resident |
| rsp_new_o | output | 1 | Symbol was placed in an unused slot |
| rsp_evict_o | output | 1 | Symbol replaced the oldest resident entry |
| rsp_slot_o | output | $clog2(DEPTH) | Slot now holding the symbol |
| rsp_evict_sym_o | output | SYM_W | Symbol that was displaced (when rsp_evict_o=1) |

## Verification
The table is reduced to four slots. It is then driven with several patterns:
- A fill from empty shows that unused slots are taken in order, lowest first.
- A repeated symbol on consecutive cycles separates correct forwarding of a fresh entry from a stale compare.
- Hits on the earliest symbol followed by a new symbol show whether hits wrongly refresh age.
- Long back-to-back streams from a symbol set larger than the table drive the replacement pointer through many wraps, and a reference model checks each response.

Idle gaps and a clear issued together with a request check that responses appear only for accepted requests, and that the pointer restarts at slot 0.

// File: rtl/cam_map_pkg.sv
package cam_map_pkg;

  // Outcome of one lookup, resolved in the request cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_HIT   = 2'd1,
    ACT_FILL  = 2'd2,
    ACT_EVICT = 2'd3
  } act_e;

endpackage

// File: rtl/cam_match_array.sv
module cam_match_array #(
  parameter int DEPTH = 16,
  parameter int SYM_W = 16,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [SYM_W-1:0]  key_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_idx_i,
  input  logic [SYM_W-1:0]  wr_sym_i,
  input  logic [SLOT_W-1:0] rd_idx_i,
  output logic [DEPTH-1:0]  match_o,
  output logic [DEPTH-1:0]  valid_o,
  output logic [SYM_W-1:0]  rd_sym_o
);

  logic [SYM_W-1:0] sym_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;

  // occupancy next state
  always_comb begin
    vld_d = vld_q;
    if (clr_i) begin
      vld_d = '0;
    end else if (wr_en_i) begin
      vld_d[wr_idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // symbol storage, one enable per entry, no reset
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      logic wr_here;
      assign wr_here = wr_en_i && !clr_i && (wr_idx_i == SLOT_W'(g));

      always_ff @(posedge clk) begin
        if (wr_here) begin
          sym_q[g] <= wr_sym_i;
        end
      end

      assign match_o[g] = vld_q[g] && (sym_q[g] == key_i);
    end
  endgenerate

  assign valid_o  = vld_q;
  assign rd_sym_o = sym_q[rd_idx_i];

  // a symbol is never resident in two slots
  p_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_o));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_o == '0));

  p_write_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i) |=> valid_o[$past(wr_idx_i)]);

endmodule

// File: rtl/cam_free_finder.sv
module cam_free_finder #(
  parameter int DEPTH = 16,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  valid_i,
  output logic [SLOT_W-1:0] free_idx_o,
  output logic              full_o
);

  // lowest unused slot: scan downward so the lowest index wins
  always_comb begin
    free_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx_o = SLOT_W'(i);
      end
    end
  end

  assign full_o = &valid_i;

endmodule

// File: rtl/cam_age_ptr.sv
module cam_age_ptr #(
  parameter int DEPTH = 16,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] ptr_o
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(DEPTH - 1);

  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  assign ptr_en = clr_i || adv_i;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i) begin
      ptr_d = '0;
    end else if (adv_i) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && ptr_o == LAST) |=> (ptr_o == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(ptr_o));

endmodule

// File: rtl/sym_slot_mapper.sv
module sym_slot_mapper
  import cam_map_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYM_W = 16,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              req_valid_i,
  input  logic [SYM_W-1:0]  req_sym_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_new_o,
  output logic              rsp_evict_o,
  output logic [SLOT_W-1:0] rsp_slot_o,
  output logic [SYM_W-1:0]  rsp_evict_sym_o
);

  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  valid;
  logic [SYM_W-1:0]  old_sym;
  logic [SLOT_W-1:0] free_idx;
  logic              full;
  logic [SLOT_W-1:0] age_ptr;
  logic [SLOT_W-1:0] hit_idx;
  act_e              act;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_idx;

  cam_match_array #(.DEPTH(DEPTH), .SYM_W(SYM_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .key_i    (req_sym_i),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_sym_i (req_sym_i),
    .rd_idx_i (age_ptr),
    .match_o  (match),
    .valid_o  (valid),
    .rd_sym_o (old_sym)
  );

  cam_free_finder #(.DEPTH(DEPTH)) u_free (
    .valid_i    (valid),
    .free_idx_o (free_idx),
    .full_o     (full)
  );

  cam_age_ptr #(.DEPTH(DEPTH)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .adv_i (act == ACT_EVICT),
    .ptr_o (age_ptr)
  );

  // one-hot match to index
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        hit_idx = hit_idx | SLOT_W'(i);
      end
    end
  end

  // resolve the request in its own cycle
  always_comb begin
    if (!req_valid_i || clr_i) begin
      act = ACT_IDLE;
    end else if (|match) begin
      act = ACT_HIT;
    end else if (!full) begin
      act = ACT_FILL;
    end else begin
      act = ACT_EVICT;
    end
  end

  assign wr_en  = (act == ACT_FILL) || (act == ACT_EVICT);
  assign wr_idx = (act == ACT_FILL) ? free_idx : age_ptr;

  // response next state
  logic              valid_d, hit_d, new_d, evict_d;
  logic [SLOT_W-1:0] slot_d;
  logic              data_en;

  always_comb begin
    valid_d = (act != ACT_IDLE);
    hit_d   = (act == ACT_HIT);
    new_d   = (act == ACT_FILL);
    evict_d = (act == ACT_EVICT);
    unique case (act)
      ACT_HIT:  slot_d = hit_idx;
      ACT_FILL: slot_d = free_idx;
      default:  slot_d = age_ptr;
    endcase
  end

  assign data_en = (act != ACT_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_new_o   <= 1'b0;
      rsp_evict_o <= 1'b0;
    end else begin
      rsp_valid_o <= valid_d;
      rsp_hit_o   <= hit_d;
      rsp_new_o   <= new_d;
      rsp_evict_o <= evict_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_slot_o      <= '0;
      rsp_evict_sym_o <= '0;
    end else if (data_en) begin
      rsp_slot_o      <= slot_d;
      rsp_evict_sym_o <= old_sym;
    end
  end

  p_evict_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EVICT) |-> full);

  p_fill_unused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_FILL) |-> !valid[free_idx]);

  p_rsp_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !clr_i));

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $onehot({rsp_hit_o, rsp_new_o, rsp_evict_o}));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> ({rsp_hit_o, rsp_new_o, rsp_evict_o} == 3'b000));

endmodule

// File: tb/sym_slot_mapper_tb.sv
`timescale 1ns/1ps
module sym_slot_mapper_tb_top;

  localparam int DEPTH  = 4;
  localparam int SYM_W  = 8;
  localparam int SLOT_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr_i = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [SYM_W-1:0]  req_sym_i = '0;
  logic              rsp_valid_o, rsp_hit_o, rsp_new_o, rsp_evict_o;
  logic [SLOT_W-1:0] rsp_slot_o;
  logic [SYM_W-1:0]  rsp_evict_sym_o;

  always #2.5 clk = ~clk;

  sym_slot_mapper #(.DEPTH(DEPTH), .SYM_W(SYM_W)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .clr_i           (clr_i),
    .req_valid_i     (req_valid_i),
    .req_sym_i       (req_sym_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_hit_o       (rsp_hit_o),
    .rsp_new_o       (rsp_new_o),
    .rsp_evict_o     (rsp_evict_o),
    .rsp_slot_o      (rsp_slot_o),
    .rsp_evict_sym_o (rsp_evict_sym_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  logic [SYM_W-1:0] m_sym [DEPTH];
  logic             m_vld [DEPTH];
  int               m_ptr;

  // expected response of the last request
  logic e_hit, e_new, e_evict;
  int   e_slot;
  logic [SYM_W-1:0] e_esym;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic model_step(input logic [SYM_W-1:0] s);
    int f;
    e_hit = 0; e_new = 0; e_evict = 0; e_slot = 0; e_esym = '0;
    f = -1;
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_sym[i] == s) begin e_hit = 1; e_slot = i; end
    if (!e_hit) begin
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) f = i;
      if (f >= 0) begin
        e_new = 1; e_slot = f; m_vld[f] = 1'b1; m_sym[f] = s;
      end else begin
        e_evict = 1; e_slot = m_ptr; e_esym = m_sym[m_ptr];
        m_sym[m_ptr] = s;
        m_ptr = (m_ptr + 1) % DEPTH;
      end
    end
  endtask

  // issue one request; response is checked one cycle later
  task automatic lookup(input logic [SYM_W-1:0] s);
    req_valid_i = 1'b1;
    req_sym_i   = s;
    model_step(s);
    @(negedge clk);
    check("R9 valid", int'(rsp_valid_o), 1);
    check("R2 hit", int'(rsp_hit_o), int'(e_hit));
    check("R3 new", int'(rsp_new_o), int'(e_new));
    check("R4 evict", int'(rsp_evict_o), int'(e_evict));
    check(e_evict ? "R5 slot" : (e_hit ? "R2 slot" : "R3 slot"), int'(rsp_slot_o), e_slot);
    if (e_evict) check("R4 evicted symbol", int'(rsp_evict_sym_o), int'(e_esym));
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    @(negedge clk);
    check("R9 idle valid", int'(rsp_valid_o), 0);
    check("R9 idle flags", int'({rsp_hit_o, rsp_new_o, rsp_evict_o}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", int'(rsp_valid_o), 0);

    // R1/R3: first miss lands in slot 0
    lookup(8'd10);
    check("R1 first slot", int'(rsp_slot_o), 0);
    // R7: same symbol on the next cycle hits
    lookup(8'd10);
    check("R7 back-to-back hit", int'(rsp_hit_o), 1);
    // R3: fill the rest in order
    lookup(8'd20);
    lookup(8'd30);
    lookup(8'd40);
    check("R3 last free slot", int'(rsp_slot_o), 3);
    idle();
    // R2: hit on every resident entry, then re-touch the oldest
    lookup(8'd40);
    lookup(8'd30);
    lookup(8'd20);
    lookup(8'd10);
    // R6: 10 still goes first
    lookup(8'd50);
    check("R6 oldest displaced", int'(rsp_evict_sym_o), 10);
    check("R6 oldest slot", int'(rsp_slot_o), 0);
    // R10: displaced symbol now misses
    lookup(8'd10);
    check("R10 displaced misses", int'(rsp_hit_o), 0);
    check("R10 displaced replaces 20", int'(rsp_evict_sym_o), 20);

    // R5: long stream through many wraps, with idle gaps
    for (int i = 0; i < 400; i++) begin
      lookup(SYM_W'((i * 7 + i / 5) % 11));
      if (i % 37 == 0) idle();
    end

    // R8: clear with a request in the same cycle
    clr_i = 1'b1;
    req_valid_i = 1'b1;
    req_sym_i = 8'd99;
    model_clear();
    @(negedge clk);
    clr_i = 1'b0;
    check("R8 request dropped", int'(rsp_valid_o), 0);
    lookup(8'd99);
    check("R8 table empty after clear", int'(rsp_new_o), 1);
    check("R8 slot 0 after clear", int'(rsp_slot_o), 0);
    lookup(8'd98);
    lookup(8'd97);
    lookup(8'd96);
    lookup(8'd95);
    check("R8 pointer restarted", int'(rsp_slot_o), 0);
    check("R8 oldest after clear", int'(rsp_evict_sym_o), 99);
    // R4: exhaustive sweep over a symbol window wider than the table
    for (int s = 0; s < 64; s++) begin
      lookup(SYM_W'(s));
      lookup(SYM_W'(s / 2));
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule